// File: doc/BRIEF.md
# Arithmetic Unit with Wide Carry Register

This block executes the one-cycle arithmetic-format operations of a small 16-bit load-store processor. It covers add and subtract in forward and reverse form, with or without carry, a two-way shift, an arithmetic right shift, move, four bitwise operations, unsigned and signed multiply, and ten compare predicates. A 16-bit carry register sits beside the general registers. It receives the upper half of every double-width result, so it serves as both a full carry/borrow word and the high word of a product or a shift.

The decoder presents a valid strobe, a 5-bit opcode, the destination register index, the value of operand a and the already-decoded value of operand b. The result, the register write enable, the skip flag and any jump request are combinational and valid in the same cycle. The carry register loads on the next rising clock edge. A result aimed at register 15, the program counter, becomes a jump request with the result as its target, and no register write is issued. Opcodes 0x10 to 0x15 (divide, modulo and unused codes) are handled elsewhere. Here they do nothing.

Top module: `wide_carry_alu`

## Requirements
- R1: add (0x00) and addc (0x01) form {carry,result} as the 32-bit sum of sign-extended a and b. addc also adds the sign-extended old carry.
- R2: sub (0x02), subc (0x03), rsb (0x04) and rsbc (0x05) form {carry,result} as a−b or b−a on sign-extended operands. The "c" forms add the sign-extended old carry, so a borrow leaves 0xFFFF in the carry.
- R3: shl (0x06) shifts the zero-extended a left by b[3:0] into a 32-bit value. If b[4]=0, the result takes the low half and the carry the high half. If b[4]=1, the two halves are swapped.
- R4: shlc (0x07) behaves as shl, but first ORs the old carry into the half that the new carry will not receive. With b=0x10, result and carry exchange.
- R5: sar (0x08) returns a arithmetically shifted right by b[3:0] and leaves the carry unchanged.
- R6: mov (0x09), and (0x0A), bcl (0x0B, a AND NOT b), or (0x0C) and xor (0x0D) write only the result. The carry holds.
- R7: mul (0x0E) and muls (0x0F) write the unsigned or signed 32-bit product to {carry,result}.
- R8: Opcodes 0x16 to 0x1F (eq, ne, signed gt, le, lt, ge, unsigned hi, ls, lo, hs, in that order) raise skip exactly when the comparison of a with b is false. They write neither result nor carry.
- R9: When a register-writing operation targets index 15, jump_req rises with jump_target equal to the result, and res_we stays low.
- R10: With op_valid low, or with opcodes 0x10 to 0x15, no write, skip or jump occurs and the carry holds.
- R11: Reset clears the carry register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Arithmetic-format opcode |
| dst_sel | input | 4 | Destination register index of operand a |
| opnd_a | input | 16 | Value of operand a |
| opnd_b | input | 16 | Decoded value of operand b |
| res_data | output | 16 | Result word |
| res_we | output | 1 | Write result to register dst_sel |
| jump_req | output | 1 | Result targets the program counter |
| jump_target | output | 16 | Jump destination |
| skip_next | output | 1 | Following instruction is to be skipped |
| carry_we | output | 1 | Carry register loads at the next edge |
| carry_nxt | output | 16 | Value the carry register will load |
| carry_q | output | 16 | Current carry register contents |

## Verification
The result, write enables, skip and jump outputs pass through no register. Each directed test therefore drives an operation after a falling edge and samples these outputs 1 ns later, in the same cycle. The carry register sits one edge downstream, so its new value is checked 1 ns after the following rising edge, before the next operation is driven. Checks that an operation left the carry alone, and chained carry tests, follow the same order, because the bench's carry model advances only at that edge.

// File: rtl/wca_pkg.sv
package wca_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'h00, OP_ADDC = 5'h01, OP_SUB  = 5'h02, OP_SUBC = 5'h03,
    OP_RSB  = 5'h04, OP_RSBC = 5'h05, OP_SHL  = 5'h06, OP_SHLC = 5'h07,
    OP_SAR  = 5'h08, OP_MOV  = 5'h09, OP_AND  = 5'h0A, OP_BCL  = 5'h0B,
    OP_OR   = 5'h0C, OP_XOR  = 5'h0D, OP_MUL  = 5'h0E, OP_MULS = 5'h0F,
    OP_R10  = 5'h10, OP_R11  = 5'h11, OP_R12  = 5'h12, OP_R13  = 5'h13,
    OP_R14  = 5'h14, OP_R15  = 5'h15,
    OP_IFEQ = 5'h16, OP_IFNE = 5'h17, OP_IFGT = 5'h18, OP_IFLE = 5'h19,
    OP_IFLT = 5'h1A, OP_IFGE = 5'h1B, OP_IFHI = 5'h1C, OP_IFLS = 5'h1D,
    OP_IFLO = 5'h1E, OP_IFHS = 5'h1F
  } wca_op_e;

  localparam logic [4:0] FIRST_CMP = 5'h16;
endpackage

// File: rtl/wca_arith.sv
module wca_arith import wca_pkg::*; #(
  parameter int W = 16
) (
  input  wca_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  output logic [W-1:0]   lo,
  output logic [W-1:0]   hi
);
  localparam int DW = 2 * W;

  function automatic logic [DW-1:0] sx(input logic [W-1:0] v);
    return {{W{v[W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] zx(input logic [W-1:0] v);
    return {{W{1'b0}}, v};
  endfunction

  logic [DW-1:0] full;

  always_comb begin
    case (op)
      OP_ADD:  full = sx(a) + sx(b);
      OP_ADDC: full = sx(a) + sx(b) + sx(c);
      OP_SUB:  full = sx(a) - sx(b);
      OP_SUBC: full = sx(a) - sx(b) + sx(c);
      OP_RSB:  full = sx(b) - sx(a);
      OP_RSBC: full = sx(b) - sx(a) + sx(c);
      OP_MUL:  full = zx(a) * zx(b);
      OP_MULS: full = sx(a) * sx(b);
      default: full = '0;
    endcase
  end

  assign lo = full[W-1:0];
  assign hi = full[DW-1:W];

  // R2
  always_comb begin
    if (op == OP_SUB && $signed(a) < $signed(b))
      sub_borrow_chk: assert (hi == {W{1'b1}});
  end
endmodule

// File: rtl/wca_shift.sv
module wca_shift import wca_pkg::*; #(
  parameter int W = 16
) (
  input  wca_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  output logic [W-1:0]   lo,
  output logic [W-1:0]   hi
);
  localparam int DW = 2 * W;
  localparam int SW = $clog2(W);

  logic [SW-1:0] amt;
  logic          swap;
  logic [DW-1:0] wide;

  assign amt  = b[SW-1:0];
  assign swap = b[SW];

  function automatic logic [DW-1:0] fill_carry(input logic [DW-1:0] p,
                                               input logic [W-1:0] cv,
                                               input logic sw);
    return sw ? (p | {cv, {W{1'b0}}}) : (p | {{W{1'b0}}, cv});
  endfunction

  always_comb begin
    wide = {{W{1'b0}}, a} << amt;
    if (op == OP_SHLC) wide = fill_carry(wide, c, swap);
    if (op == OP_SAR) begin
      lo = W'($signed(a) >>> amt);
      hi = c;
    end else if (!swap) begin
      lo = wide[W-1:0];
      hi = wide[DW-1:W];
    end else begin
      lo = wide[DW-1:W];
      hi = wide[W-1:0];
    end
  end

  // R3
  always_comb begin
    if (op == OP_SHL && !swap)
      shl_lossless_chk: assert (({hi, lo} >> amt) == {{W{1'b0}}, a});
  end
endmodule

// File: rtl/wca_cmp.sv
module wca_cmp import wca_pkg::*; #(
  parameter int W = 16
) (
  input  wca_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           skip
);
  logic pass;
  logic s_lt, u_lt, eq;

  assign eq   = (a == b);
  assign s_lt = ($signed(a) < $signed(b));
  assign u_lt = (a < b);

  always_comb begin
    case (op)
      OP_IFEQ: pass = eq;
      OP_IFNE: pass = !eq;
      OP_IFGT: pass = !s_lt && !eq;
      OP_IFLE: pass = s_lt || eq;
      OP_IFLT: pass = s_lt;
      OP_IFGE: pass = !s_lt;
      OP_IFHI: pass = !u_lt && !eq;
      OP_IFLS: pass = u_lt || eq;
      OP_IFLO: pass = u_lt;
      OP_IFHS: pass = !u_lt;
      default: pass = 1'b1;
    endcase
  end

  assign skip = !pass;

  // R8
  always_comb begin
    if (op == OP_IFEQ || op == OP_IFNE)
      eq_pair_chk: assert (skip == ((op == OP_IFEQ) ? (a != b) : (a == b)));
  end
endmodule

// File: rtl/wide_carry_alu.sv
module wide_carry_alu import wca_pkg::*; #(
  parameter int W  = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [RW-1:0] dst_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  output logic [W-1:0]  res_data,
  output logic          res_we,
  output logic          jump_req,
  output logic [W-1:0]  jump_target,
  output logic          skip_next,
  output logic          carry_we,
  output logic [W-1:0]  carry_nxt,
  output logic [W-1:0]  carry_q
);
  localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};

  wca_op_e      op;
  logic [W-1:0] ar_lo, ar_hi, sh_lo, sh_hi;
  logic         cmp_skip;
  logic         is_arith, is_shift, is_logic, is_cmp;
  logic         wr_a, wr_c, to_pc;
  logic [W-1:0] logic_res;

  assign op = wca_op_e'(op_code);

  wca_arith #(.W(W)) u_arith (.op(op), .a(opnd_a), .b(opnd_b), .c(carry_q),
                              .lo(ar_lo), .hi(ar_hi));
  wca_shift #(.W(W)) u_shift (.op(op), .a(opnd_a), .b(opnd_b), .c(carry_q),
                              .lo(sh_lo), .hi(sh_hi));
  wca_cmp   #(.W(W)) u_cmp   (.op(op), .a(opnd_a), .b(opnd_b), .skip(cmp_skip));

  always_comb begin
    is_arith = 1'b0; is_shift = 1'b0; is_logic = 1'b0;
    logic_res = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSB, OP_RSBC,
      OP_MUL, OP_MULS:        is_arith = 1'b1;
      OP_SHL, OP_SHLC, OP_SAR: is_shift = 1'b1;
      OP_MOV: begin is_logic = 1'b1; logic_res = opnd_b;            end
      OP_AND: begin is_logic = 1'b1; logic_res = opnd_a & opnd_b;   end
      OP_BCL: begin is_logic = 1'b1; logic_res = opnd_a & ~opnd_b;  end
      OP_OR:  begin is_logic = 1'b1; logic_res = opnd_a | opnd_b;   end
      OP_XOR: begin is_logic = 1'b1; logic_res = opnd_a ^ opnd_b;   end
      default: ;
    endcase
  end

  assign is_cmp = (op_code >= FIRST_CMP);

  always_comb begin
    if (is_arith)      res_data = ar_lo;
    else if (is_shift) res_data = sh_lo;
    else               res_data = logic_res;
  end

  assign carry_nxt = is_arith ? ar_hi : sh_hi;

  assign wr_a  = op_valid && (is_arith || is_shift || is_logic);
  assign wr_c  = op_valid && (is_arith || (is_shift && op != OP_SAR));
  assign to_pc = (dst_sel == PC_IDX);

  assign res_we      = wr_a && !to_pc;
  assign jump_req    = wr_a && to_pc;
  assign jump_target = res_data;
  assign skip_next   = op_valid && is_cmp && cmp_skip;
  assign carry_we    = wr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= '0;
    else if (carry_we) carry_q <= carry_nxt;
  end

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_we |=> $stable(carry_q));

  // R8
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> (!res_we && !carry_we && !jump_req));

  // R9
  jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_we, jump_req, skip_next}) <= 1);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !(res_we || jump_req || skip_next || carry_we));

  // R5
  sar_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_SAR) |=> $stable(carry_q));
endmodule

// File: tb/wide_carry_alu_test.sv
`timescale 1ns/1ps
module wide_carry_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [3:0]  dst_sel = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] res_data, jump_target, carry_nxt, carry_q;
  logic        res_we, jump_req, skip_next, carry_we;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mc = '0;

  always #2.5 clk = ~clk;

  wide_carry_alu uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .op_code(op_code), .dst_sel(dst_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_data(res_data), .res_we(res_we), .jump_req(jump_req),
    .jump_target(jump_target), .skip_next(skip_next), .carry_we(carry_we),
    .carry_nxt(carry_nxt), .carry_q(carry_q));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent reference: integer arithmetic on sign/zero-extended values.
  task automatic model(input logic [4:0] op, input logic [15:0] a, b, c,
                       output logic [15:0] r, output logic [15:0] nc,
                       output bit wa, output bit wc, output bit sk);
    int sa = int'($signed(a)), sb = int'($signed(b)), sc = int'($signed(c));
    int ua = int'(a), ub = int'(b);
    int k = int'(b[3:0]);
    logic [31:0] t;
    bit cond;
    r = '0; nc = c; wa = 0; wc = 0; sk = 0; t = '0; cond = 1;
    case (op)
      5'h00: t = sa + sb;            5'h01: t = sa + sb + sc;
      5'h02: t = sa - sb;            5'h03: t = sa - sb + sc;
      5'h04: t = sb - sa;            5'h05: t = sb - sa + sc;
      5'h0E: t = ua * ub;            5'h0F: t = sa * sb;
      default: ;
    endcase
    if (op <= 5'h05 || op == 5'h0E || op == 5'h0F) begin
      r = t[15:0]; nc = t[31:16]; wa = 1; wc = 1;
    end else if (op == 5'h06 || op == 5'h07) begin
      wa = 1; wc = 1;
      if (!b[4]) begin
        r  = 16'(ua << k) | ((op == 5'h07) ? c : 16'h0);
        nc = 16'(ua >> (16 - k));
      end else begin
        r  = 16'(ua >> (16 - k)) | ((op == 5'h07) ? c : 16'h0);
        nc = 16'(ua << k);
      end
    end else if (op == 5'h08) begin
      wa = 1; r = 16'(sa >>> k);
    end else if (op >= 5'h09 && op <= 5'h0D) begin
      wa = 1;
      case (op)
        5'h09: r = b;   5'h0A: r = a & b; 5'h0B: r = a & ~b;
        5'h0C: r = a | b; default: r = a ^ b;
      endcase
    end else if (op >= 5'h16) begin
      case (op)
        5'h16: cond = (a == b);  5'h17: cond = (a != b);
        5'h18: cond = (sa > sb); 5'h19: cond = (sa <= sb);
        5'h1A: cond = (sa < sb); 5'h1B: cond = (sa >= sb);
        5'h1C: cond = (a > b);   5'h1D: cond = (a <= b);
        5'h1E: cond = (a < b);   default: cond = (a >= b);
      endcase
      sk = !cond;
    end
  endtask

  task automatic run(input string tag, input logic [4:0] op, input logic [3:0] dst,
                     input logic [15:0] a, b, input bit valid = 1);
    logic [15:0] er, enc; bit ewa, ewc, esk;
    model(op, a, b, mc, er, enc, ewa, ewc, esk);
    if (!valid) begin ewa = 0; ewc = 0; esk = 0; enc = mc; end
    @(negedge clk);
    op_valid = valid; op_code = op; dst_sel = dst; opnd_a = a; opnd_b = b;
    #1;
    chk({tag, " res_we"},   res_we,   ewa && dst != 4'hF);
    chk({tag, " jump_req"}, jump_req, ewa && dst == 4'hF);
    chk({tag, " skip"},     skip_next, esk);
    chk({tag, " carry_we"}, carry_we, ewc);
    if (ewa && dst != 4'hF) chk({tag, " result"}, res_data, er);
    if (ewa && dst == 4'hF) chk({tag, " target"}, jump_target, er);
    @(posedge clk); #1;
    op_valid = 0;
    if (ewc) mc = enc;
    chk({tag, " carry"}, carry_q, mc);
  endtask

  task automatic t_reset();
    chk("R11 carry after reset", carry_q, 16'h0);
    chk("R10 idle res_we", res_we, 1'b0);
  endtask

  task automatic t_addsub();
    run("R1 add plain", 5'h00, 4'd1, 16'h7000, 16'h1000);
    run("R1 add neg wrap", 5'h00, 4'd1, 16'h8000, 16'h8000);
    chk("R1 add high word", carry_q, 16'hFFFF);
    run("R1 addc", 5'h01, 4'd2, 16'h0010, 16'h0003);
    run("R2 sub borrow", 5'h02, 4'd3, 16'h0003, 16'h0005);
    chk("R2 borrow carry", carry_q, 16'hFFFF);
    run("R2 subc chain", 5'h03, 4'd3, 16'h000A, 16'h0002);
    run("R2 rsb", 5'h04, 4'd4, 16'h0009, 16'h0004);
    run("R2 rsbc", 5'h05, 4'd4, 16'h1234, 16'h5678);
  endtask

  task automatic t_shift();
    run("R3 shl left", 5'h06, 4'd5, 16'h8001, 16'h0001);
    run("R3 shl swapped", 5'h06, 4'd5, 16'h1234, 16'h0014);
    run("R3 shl by zero", 5'h06, 4'd5, 16'hABCD, 16'h0000);
    run("R4 shl set carry", 5'h06, 4'd6, 16'h5A5A, 16'h0010);
    run("R4 shlc exchange", 5'h07, 4'd6, 16'h0F0F, 16'h0010);
    chk("R4 exchanged carry", carry_q, 16'h0F0F);
    run("R4 shlc left", 5'h07, 4'd6, 16'h4000, 16'h0002);
    run("R4 shlc swapped", 5'h07, 4'd6, 16'h00F0, 16'h0018);
  endtask

  task automatic t_sar_logic();
    logic [15:0] keep;
    keep = mc;
    run("R5 sar negative", 5'h08, 4'd7, 16'h8000, 16'h0003);
    run("R5 sar positive", 5'h08, 4'd7, 16'h7F00, 16'h0004);
    run("R6 mov", 5'h09, 4'd7, 16'h1111, 16'hBEEF);
    run("R6 and", 5'h0A, 4'd7, 16'hF0F0, 16'h3C3C);
    run("R6 bcl", 5'h0B, 4'd7, 16'hFFFF, 16'h00FF);
    run("R6 or",  5'h0C, 4'd7, 16'h1200, 16'h0034);
    run("R6 xor", 5'h0D, 4'd7, 16'h5555, 16'hFFFF);
    chk("R6 carry untouched", carry_q, keep);
  endtask

  task automatic t_mul();
    run("R7 mul unsigned", 5'h0E, 4'd8, 16'hFFFF, 16'hFFFF);
    chk("R7 unsigned high", carry_q, 16'hFFFE);
    run("R7 muls signed", 5'h0F, 4'd8, 16'hFFFF, 16'hFFFF);
    chk("R7 signed high", carry_q, 16'h0000);
    run("R7 muls mixed", 5'h0F, 4'd8, 16'h8000, 16'h0002);
  endtask

  task automatic t_cmp();
    logic [15:0] pa [3] = '{16'h0005, 16'hFFFF, 16'h0005};
    logic [15:0] pb [3] = '{16'h0005, 16'h0001, 16'h0009};
    logic [15:0] keep;
    keep = mc;
    for (int op = 5'h16; op <= 5'h1F; op++)
      for (int i = 0; i < 3; i++)
        run($sformatf("R8 cmp op%0h pair%0d", op, i), 5'(op), 4'd9, pa[i], pb[i]);
    chk("R8 cmp carry untouched", carry_q, keep);
  endtask

  task automatic t_jump();
    run("R9 mov to pc", 5'h09, 4'hF, 16'h0000, 16'h1234);
    run("R9 add to pc", 5'h00, 4'hF, 16'h0100, 16'h0020);
  endtask

  task automatic t_quiet();
    logic [15:0] keep;
    keep = mc;
    run("R10 idle add", 5'h00, 4'd1, 16'h8000, 16'h8000, 0);
    run("R10 idle cmp", 5'h16, 4'd1, 16'h0001, 16'h0002, 0);
    for (int op = 5'h10; op <= 5'h15; op++)
      run($sformatf("R10 reserved op%0h", op), 5'(op), 4'd2, 16'hFFFF, 16'h0001);
    chk("R10 carry untouched", carry_q, keep);
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_addsub();
    t_shift();
    t_sar_logic();
    t_mul();
    t_cmp();
    t_jump();
    t_quiet();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule